// File: doc/BRIEF.md
# DRAM Power-On Initialization Sequencer

This block owns the command pins of a double-data-rate DRAM controller from reset until the memory is ready for ordinary traffic. Once reset is released, it holds a no-op on the command pins for a programmable settling interval. It then steps through a fixed bring-up order: precharge of every bank, a write to the extended mode register, a write to the base mode register with the DLL-reset bit set, and a programmable number of auto-refresh commands. Each command is spaced from the one before it by the minimum gap that belongs to it. A final wait follows, and then the ready flag goes high.

Every nanosecond minimum is a parameter in picoseconds. It is turned into whole clock cycles with the clock period parameter, always rounding upward. Both mode-register opcodes are parameters. The sequencer forces only the DLL-reset bit of the base opcode. Between commands, and from the moment the flag rises until the next reset, the pins carry a no-op with zero address and bank. Asserting reset at any point aborts the sequence and restarts it from the beginning.

Top module: `dram_init_seq`

## Requirements
- R1: While reset is asserted, and through the wait that follows its release, the pins carry a no-op: chip select low, the row, column and write strobes high, bank 00 and address 0. `init_done` is 0.
- R2: The first other command is precharge-all. It is encoded as row strobe 0, column strobe 1, write strobe 0, with address bit 10 set, every other address bit 0, and bank 00. It appears right after the STABLE_CYC-th rising edge that follows reset release.
- R3: In every cycle that does not carry one of the listed commands, the pins carry the no-op of R1, with bank and address zero.
- R4: The extended mode-register write follows precharge-all after exactly the precharge gap in cycles. It is encoded with all four strobes 0, bank 01 and address EMR_OPCODE. In that opcode, bit 0 = 0 keeps the DLL enabled and bit 1 = 0 selects normal drive strength. Bank codes 1x are never driven.
- R5: The base mode-register write follows the extended write after exactly the mode-write gap. It is encoded with all strobes 0, bank 00 and address MR_OPCODE with bit 8 (DLL reset) forced to 1.
- R6: Auto-refresh is encoded as row and column strobes 0, write strobe 1, bank 00 and address 0. The first refresh comes exactly one mode-write gap after the base write. The rest follow one refresh gap apart, for REF_COUNT refreshes in total.
- R7: `init_done` rises exactly FINAL_WAIT cycles after the last refresh, where FINAL_WAIT is the larger of FINAL_CYC and the refresh gap. It then stays high, and the pins stay at no-op until the next reset.
- R8: Each gap in cycles is the ceiling of the picosecond minimum divided by CLK_PERIOD_PS, and is never less than 1.
- R9: A REF_COUNT below 2 is raised to 2.
- R10: A reset asserted at any time, including mid-sequence or after `init_done`, drops `init_done` and returns the pins to no-op at once. After release, the whole sequence repeats from R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset; restarts the sequence |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| ba | output | BA_W | Bank address (mode-register select during mode writes) |
| addr | output | ADDR_W | Address bus (opcode during mode writes) |
| init_done | output | 1 | High once the bring-up sequence has completed |

## Verification
The assertions check several properties on every cycle. `init_done` never rises before all refreshes are spent, and never falls while reset is inactive. The flag stays low in every phase before the last one. Every base mode write carries the DLL-reset bit, and no mode write drives a reserved bank code. The gap counter never skips or wraps. Exact cycle placement cannot be shown by a per-cycle property: the spacing of each command, the ceiling rounding at an uneven clock period, the clamp on the refresh count, and a restart from mid-sequence or after completion. The bench's scenarios show these by comparing every pin, every cycle, against a schedule it computes itself for three parameter sets.

// File: rtl/dis_pkg.sv
package dis_pkg;

    // Address bit positions that the memory decodes
    localparam int PRE_ALL_BIT = 10;
    localparam int DLL_RST_BIT = 8;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_PRE_ALL,
        CMD_MODE_EXT,
        CMD_MODE_BASE,
        CMD_REFRESH
    } cmd_e;

    typedef enum logic [2:0] {
        PH_SETTLE,
        PH_PRE_GAP,
        PH_EXT_GAP,
        PH_BASE_GAP,
        PH_REF_GAP,
        PH_FINAL,
        PH_DONE
    } phase_e;

    // Minimum time in picoseconds to whole cycles, rounded up, at least one
    function automatic int ps_to_cycles(input int min_ps, input int period_ps);
        int c;
        c = (min_ps + period_ps - 1) / period_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dis_gap_timer.sv
module dis_gap_timer #(
    parameter int CNT_W   = 16,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RST_VAL);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt     = cnt_q;
    assign expired = (cnt_q == '0);

    // R8: the gap counter steps down by exactly one while waiting
    a_r8_gap_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R8: an expired counter stays at zero until reloaded
    a_r8_gap_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/dis_cmd_encode.sv
module dis_cmd_encode #(
    parameter int              BA_W       = 2,
    parameter int              ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] EXT_OPCODE = '0,
    parameter logic [ADDR_W-1:0] BASE_OPCODE = '0
) (
    input  dis_pkg::cmd_e      cmd,
    output logic               cs_n,
    output logic               ras_n,
    output logic               cas_n,
    output logic               we_n,
    output logic [BA_W-1:0]    ba,
    output logic [ADDR_W-1:0]  addr
);
    import dis_pkg::*;

    localparam logic [ADDR_W-1:0] PRE_ALL_ADDR = ADDR_W'(1) << PRE_ALL_BIT;
    localparam logic [ADDR_W-1:0] DLL_RST_MASK = ADDR_W'(1) << DLL_RST_BIT;
    localparam logic [BA_W-1:0]   SEL_BASE     = BA_W'(0);
    localparam logic [BA_W-1:0]   SEL_EXT      = BA_W'(1);

    always_comb begin
        cs_n  = 1'b0;
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        ba    = '0;
        addr  = '0;
        unique case (cmd)
            CMD_PRE_ALL: begin
                ras_n = 1'b0;
                we_n  = 1'b0;
                addr  = PRE_ALL_ADDR;
            end
            CMD_MODE_EXT: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                we_n  = 1'b0;
                ba    = SEL_EXT;
                addr  = EXT_OPCODE;
            end
            CMD_MODE_BASE: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                we_n  = 1'b0;
                ba    = SEL_BASE;
                addr  = BASE_OPCODE | DLL_RST_MASK;
            end
            CMD_REFRESH: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq #(
    parameter int                CLK_PERIOD_PS = 20000,
    parameter int                STABLE_CYC    = 10000,
    parameter int                T_RP_PS       = 20000,
    parameter int                T_MRD_PS      = 15000,
    parameter int                T_RFC_PS      = 75000,
    parameter int                REF_COUNT     = 2,
    parameter int                FINAL_CYC     = 200,
    parameter int                BA_W          = 2,
    parameter int                ADDR_W        = 12,
    parameter logic [ADDR_W-1:0] EMR_OPCODE    = 12'h000,
    parameter logic [ADDR_W-1:0] MR_OPCODE     = 12'h022
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);
    import dis_pkg::*;

    localparam int RP_CYC     = ps_to_cycles(T_RP_PS, CLK_PERIOD_PS);
    localparam int MRD_CYC    = ps_to_cycles(T_MRD_PS, CLK_PERIOD_PS);
    localparam int RFC_CYC    = ps_to_cycles(T_RFC_PS, CLK_PERIOD_PS);
    localparam int REF_N      = (REF_COUNT < 2) ? 2 : REF_COUNT;
    localparam int FINAL_WAIT = imax(FINAL_CYC, RFC_CYC);
    localparam int SETTLE     = imax(STABLE_CYC, 1);
    localparam int MAX_GAP    = imax(imax(SETTLE, FINAL_WAIT), imax(imax(RP_CYC, MRD_CYC), RFC_CYC));
    localparam int CNT_W      = $clog2(MAX_GAP + 1);
    localparam int REF_W      = $clog2(REF_N + 1);

    typedef struct packed {
        phase_e           phase;
        cmd_e             cmd;
        logic [REF_W-1:0] ref_left;
        logic             ready;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic             gap_load;
    logic [CNT_W-1:0] gap_val;
    logic [CNT_W-1:0] gap_cnt;
    logic             gap_expired;

    dis_gap_timer #(
        .CNT_W  (CNT_W),
        .RST_VAL(SETTLE - 1)
    ) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gap_load),
        .load_val(gap_val),
        .cnt     (gap_cnt),
        .expired (gap_expired)
    );

    // Next state: one command per expired gap, no-op otherwise
    always_comb begin
        seq_d     = seq_q;
        seq_d.cmd = CMD_NOP;
        gap_load  = 1'b0;
        gap_val   = '0;
        if (gap_expired) begin
            unique case (seq_q.phase)
                PH_SETTLE: begin
                    seq_d.cmd   = CMD_PRE_ALL;
                    seq_d.phase = PH_PRE_GAP;
                    gap_load    = 1'b1;
                    gap_val     = CNT_W'(RP_CYC - 1);
                end
                PH_PRE_GAP: begin
                    seq_d.cmd   = CMD_MODE_EXT;
                    seq_d.phase = PH_EXT_GAP;
                    gap_load    = 1'b1;
                    gap_val     = CNT_W'(MRD_CYC - 1);
                end
                PH_EXT_GAP: begin
                    seq_d.cmd      = CMD_MODE_BASE;
                    seq_d.phase    = PH_BASE_GAP;
                    seq_d.ref_left = REF_W'(REF_N);
                    gap_load       = 1'b1;
                    gap_val        = CNT_W'(MRD_CYC - 1);
                end
                PH_BASE_GAP, PH_REF_GAP: begin
                    seq_d.cmd      = CMD_REFRESH;
                    seq_d.ref_left = seq_q.ref_left - 1'b1;
                    gap_load       = 1'b1;
                    if (seq_q.ref_left == REF_W'(1)) begin
                        seq_d.phase = PH_FINAL;
                        gap_val     = CNT_W'(FINAL_WAIT - 1);
                    end else begin
                        seq_d.phase = PH_REF_GAP;
                        gap_val     = CNT_W'(RFC_CYC - 1);
                    end
                end
                PH_FINAL: begin
                    seq_d.ready = 1'b1;
                    seq_d.phase = PH_DONE;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{phase: PH_SETTLE, cmd: CMD_NOP, ref_left: '0, ready: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    dis_cmd_encode #(
        .BA_W       (BA_W),
        .ADDR_W     (ADDR_W),
        .EXT_OPCODE (EMR_OPCODE),
        .BASE_OPCODE(MR_OPCODE)
    ) u_enc (
        .cmd  (seq_q.cmd),
        .cs_n (cs_n),
        .ras_n(ras_n),
        .cas_n(cas_n),
        .we_n (we_n),
        .ba   (ba),
        .addr (addr)
    );

    assign init_done = seq_q.ready;

    // R1: flag low in every phase before completion
    a_r1_ready_low_early: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase != PH_DONE) |-> !init_done);

    // R7: once high the flag holds until reset
    a_r7_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R6: flag rises only after every refresh was issued
    a_r6_refs_spent: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (seq_q.ref_left == '0));

    // R7: no command on the pins after completion
    a_r7_idle_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (!cs_n && ras_n && cas_n && we_n));

    // R5: base mode write always carries the DLL reset bit
    a_r5_dll_reset_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n && !cas_n && !we_n && ba == BA_W'(0)) |-> addr[DLL_RST_BIT]);

    // R4: mode writes never select a reserved register code
    a_r4_no_reserved_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n && !cas_n && !we_n) |-> (ba == BA_W'(0) || ba == BA_W'(1)));

endmodule

// File: tb/dram_init_seq_tb.sv
module dram_init_seq_tb;

    localparam int NI = 3;
    // per-instance settings: nominal, uneven period, clamped refresh count
    localparam int P_PER [NI] = '{20000, 7000, 20000};
    localparam int P_STB [NI] = '{10000, 50, 20};
    localparam int P_REF [NI] = '{2, 3, 1};
    localparam int P_FIN [NI] = '{200, 20, 2};
    localparam logic [11:0] P_EMR [NI] = '{12'h000, 12'h002, 12'h000};
    localparam logic [11:0] P_MR  [NI] = '{12'h022, 12'h032, 12'h061};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [18:0] obs [NI];
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    for (genvar g = 0; g < NI; g++) begin : g_inst
        logic cs_n, ras_n, cas_n, we_n, rdy;
        logic [1:0]  ba;
        logic [11:0] addr;
        if (g == 0) begin : g_main
            dram_init_seq #(
                .CLK_PERIOD_PS(P_PER[g]), .STABLE_CYC(P_STB[g]), .REF_COUNT(P_REF[g]),
                .FINAL_CYC(P_FIN[g]), .EMR_OPCODE(P_EMR[g]), .MR_OPCODE(P_MR[g])
            ) u_dut (
                .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
                .we_n(we_n), .ba(ba), .addr(addr), .init_done(rdy));
        end else begin : g_alt
            dram_init_seq #(
                .CLK_PERIOD_PS(P_PER[g]), .STABLE_CYC(P_STB[g]), .REF_COUNT(P_REF[g]),
                .FINAL_CYC(P_FIN[g]), .EMR_OPCODE(P_EMR[g]), .MR_OPCODE(P_MR[g])
            ) u_dut_alt (
                .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
                .we_n(we_n), .ba(ba), .addr(addr), .init_done(rdy));
        end
        assign obs[g] = {rdy, cs_n, ras_n, cas_n, we_n, ba, addr};
    end

    function automatic int cdiv(input int a, input int b);
        int c = (a + b - 1) / b;
        return (c < 1) ? 1 : c;
    endfunction

    // Expected pins after rising edge k (k = 0: in or right after reset)
    task automatic expect_at(input int i, input int k, output logic [18:0] w, output string tag);
        int rp = cdiv(20000, P_PER[i]);
        int mrd = cdiv(15000, P_PER[i]);
        int rfc = cdiv(75000, P_PER[i]);
        int nref = (P_REF[i] < 2) ? 2 : P_REF[i];
        int fin = (P_FIN[i] > rfc) ? P_FIN[i] : rfc;
        int e_pre = P_STB[i];
        int e_ext = e_pre + rp;
        int e_base = e_ext + mrd;
        int e_ref0 = e_base + mrd;
        int e_rdy = e_ref0 + (nref - 1) * rfc + fin;
        logic rdy = (k >= e_rdy);
        w = {rdy, 4'b0111, 2'b00, 12'h000};
        tag = rdy ? "R7" : ((k == 0) ? "R1" : "R3");
        if (k > 0 && k == e_pre) begin
            w = {rdy, 4'b0010, 2'b00, 12'h400}; tag = "R2";
        end else if (k > 0 && k == e_ext) begin
            w = {rdy, 4'b0000, 2'b01, P_EMR[i]}; tag = "R4";
        end else if (k > 0 && k == e_base) begin
            w = {rdy, 4'b0000, 2'b00, P_MR[i] | 12'h100}; tag = "R5";
        end else if (k >= e_ref0 && k < e_rdy && ((k - e_ref0) % rfc) == 0
                     && (k - e_ref0) / rfc < nref) begin
            w = {rdy, 4'b0001, 2'b00, 12'h000}; tag = "R6";
        end
        if (k == e_rdy) tag = "R7";
        if (i == 1) tag = {tag, "/R8"};
        if (i == 2) tag = {tag, "/R9"};
    endtask

    task automatic check_all(input int k, input string extra);
        logic [18:0] w;
        string tag;
        for (int i = 0; i < NI; i++) begin
            expect_at(i, k, w, tag);
            n_checks++;
            if (obs[i] !== w) begin
                n_fail++;
                $display("FAIL %s%s inst %0d cycle %0d: got %h expected %h", tag, extra, i, k, obs[i], w);
            end
        end
    endtask

    task automatic run_cycles(input int kmax, input string extra);
        for (int k = 1; k <= kmax; k++) begin
            @(posedge clk);
            @(negedge clk);
            check_all(k, extra);
        end
    endtask

    // R1: reset holds no-op and a low flag
    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_all(0, " reset");
    endtask

    // R2..R9: full sequence checked pin by pin each cycle
    task automatic t_full_sequence();
        @(negedge clk);
        rst_n = 1'b1;
        run_cycles(10215, "");
    endtask

    // R10: reset after completion drops the flag at once
    task automatic t_reset_after_ready();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_all(0, " R10 post-ready reset");
        repeat (2) @(negedge clk);
        check_all(0, " R10 post-ready reset");
    endtask

    // R10: reset in the middle of refreshes restarts from the top
    task automatic t_restart_mid();
        @(negedge clk);
        rst_n = 1'b1;
        run_cycles(10004, " R10 first pass");
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_all(0, " R10 mid reset");
        repeat (2) @(negedge clk);
        check_all(0, " R10 mid reset");
        rst_n = 1'b1;
        run_cycles(10215, " R10 rerun");
    endtask

    initial begin
        t_reset_state();
        t_full_sequence();
        t_reset_after_ready();
        t_restart_mid();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule